// File: doc/BRIEF.md
# Serial Audio Transmitter with Dithered Truncation

The block serialises one stereo pair of 24-bit two's-complement samples per frame onto a single data line. An external source supplies the bit clock and a frame clock. Both are sampled in the block's system clock domain, and every transition of the data line follows a falling bit-clock edge. A 2-bit format input selects the framing: left-justified, I2S, a slot-based TDM layout, or right-justified. A 2-bit width input selects the length of the audio word.

When the word is shorter than 24 bits, a pseudo-random value is added into the bits about to be discarded before they are cleared. The addition saturates, so a sample near positive full scale does not wrap. An optional auxiliary byte per channel can be carried in bit positions that audio does not use. A packed mode sends two 16-bit words in a 32-clock frame. All inputs are captured at the frame boundary, so both channels of a frame always come from the same input pair.

Top module: `audio_serial_tx`

## Requirements
- R1: A frame starts on a bit-clock falling edge where `frame_i` is high and was low at the previous falling edge. That bit is frame position 0, and each later falling edge advances the position by one. With format code 00 (left-justified), the left word starts at position 0 and the right word starts at position 32, each sent MSB first.
- R2: Format code 01 (I2S) sends exactly the bit stream that code 00 would produce, delayed by one bit clock. Frame position 0 therefore carries the last bit computed for the previous frame.
- R3: Format code 10 (TDM) places the left slot at positions 0 to 31 and the right slot at positions 32 to 63. A one-bit-clock frame pulse starts the frame, and from position 64 until the next frame start the line is low.
- R4: Format code 11 (right-justified) ends each word on the last bit of its 32-bit subframe, at position 31 or 63. The positions between the auxiliary field and the word are low.
- R5: Width code 00 sends 24 bits, 01 sends 20, 10 sends 18 and 11 sends 16. In the non-right-justified formats, subframe bits from the word length up to bit 23 are low.
- R6: Dither comes from a 16-bit LFSR with seed 0xACE1. On each step the state shifts left and the feedback, the XOR of bits 15, 13, 12 and 10, enters at bit 0. The LFSR steps once at every frame start, after the frame has used its value. The left channel adds bits 7:0 and the right channel adds bits 15:8, each masked to the number of discarded bits (0, 4, 6 or 8). The discarded bits are then cleared. At 24 bits the sample passes through unchanged.
- R7: A non-negative sample never becomes negative through dither. An overflow saturates to 0x7FFFFF before the low bits are cleared.
- R8: With `aux_en_i` high, the auxiliary byte goes MSB first into subframe bits 24 to 31 in the left-justified, I2S and TDM layouts, and into subframe bits 0 to 7 in the right-justified layout. With `aux_en_i` low, those bits are low.
- R9: When `packed_i` is high with format 00 or 01, the frame is 32 positions long. The left 16-bit word is at positions 0 to 15 and the right 16-bit word at positions 16 to 31, dither uses 8 discarded bits, the width code and the auxiliary data are ignored, and the line is low from position 32 on. With format 10 or 11, `packed_i` has no effect.
- R10: Samples, auxiliary bytes, format, width, packing and the auxiliary enable are captured only at a frame start. Changes during a frame do not alter that frame.
- R11: After reset `sdata_o` is low. It changes only in the system-clock cycle that follows a detected falling edge of the bit clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock sampling the serial clocks |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Bit clock from the clock source |
| frame_i | input | 1 | Frame clock or frame pulse |
| fmt_i | input | 2 | Output format code |
| width_i | input | 2 | Output word-length code |
| packed_i | input | 1 | Packed 16-bit, 32-clock framing |
| aux_en_i | input | 1 | Send auxiliary bytes |
| left_i | input | 24 | Left sample, two's complement |
| right_i | input | 24 | Right sample, two's complement |
| aux_left_i | input | 8 | Auxiliary byte for the left subframe |
| aux_right_i | input | 8 | Auxiliary byte for the right subframe |
| sdata_o | output | 1 | Serial data line |

## Verification
The assertions check several properties on every cycle. The data line moves only after a falling edge. The position restarts at a frame start. The LFSR never reaches the all-zero state. Dither never turns a non-negative sample negative. The captured words hold still between frame starts. The line stays low in the tail of a left-justified, TDM, right-justified or packed frame. The exact bit placement can only be shown by the bench's frame scenarios, which compare every bit clock against a model built from the requirements. That placement covers the four layouts, the four widths, the auxiliary field, the one-bit I2S delay across frame boundaries, the LFSR sequence, saturation at positive full scale, packing and capture at the frame boundary.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;
  localparam int SMP_W  = 24;
  localparam int AUX_W  = 8;
  localparam int SUB_W  = 32;
  localparam int PK_W   = 16;
  localparam int LFSR_W = 16;

  typedef enum logic [1:0] {
    FMT_LJ  = 2'b00,
    FMT_I2S = 2'b01,
    FMT_TDM = 2'b10,
    FMT_RJ  = 2'b11
  } fmt_e;

  // number of low bits discarded for a width code
  function automatic logic [3:0] drop_count(input logic [1:0] wcode, input logic pk);
    logic [3:0] d;
    if (pk) d = 4'd8;
    else begin
      case (wcode)
        2'b00:   d = 4'd0;
        2'b01:   d = 4'd4;
        2'b10:   d = 4'd6;
        default: d = 4'd8;
      endcase
    end
    return d;
  endfunction
endpackage

// File: rtl/atx_edge_ctrl.sv
module atx_edge_ctrl #(
  parameter int POS_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bclk_i,
  input  logic             frame_i,
  output logic             fall_o,
  output logic             start_o,
  output logic [POS_W-1:0] pos_o,
  output logic [POS_W-1:0] pos_next_o
);
  logic             bclk_q;
  logic             frame_q;
  logic [POS_W-1:0] pos_q;

  assign fall_o     = bclk_q & ~bclk_i;
  assign start_o    = fall_o & frame_i & ~frame_q;
  // position saturates so long gaps stay quiet
  assign pos_next_o = start_o ? '0 : ((&pos_q) ? pos_q : pos_q + 1'b1);
  assign pos_o      = pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q  <= 1'b0;
      frame_q <= 1'b0;
      pos_q   <= '1;
    end else begin
      bclk_q <= bclk_i;
      if (fall_o) begin
        frame_q <= frame_i;
        pos_q   <= pos_next_o;
      end
    end
  end

  a_r1_pos_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_o && start_o) |=> (pos_o == '0));
endmodule

// File: rtl/atx_dither.sv
module atx_dither
  import audio_tx_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 adv_i,
  input  logic [3:0]           drop_i,
  input  logic [1:0][SMP_W-1:0] smp_i,
  output logic [1:0][SMP_W-1:0] word_o
);
  localparam int DW = LFSR_W / 2;

  logic [LFSR_W-1:0] lfsr_q;
  logic              fb;
  logic [SMP_W-1:0]  mask;

  assign fb   = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];
  assign mask = (SMP_W'(1) << drop_i) - SMP_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lfsr_q <= SEED;
    else if (adv_i) lfsr_q <= {lfsr_q[LFSR_W-2:0], fb};
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    logic [SMP_W-1:0] dith;
    logic [SMP_W:0]   sum;
    logic             ovf;
    logic [SMP_W-1:0] sat;

    assign dith = SMP_W'(lfsr_q[ch*DW +: DW]) & mask;
    assign sum  = {smp_i[ch][SMP_W-1], smp_i[ch]} + {1'b0, dith};
    assign ovf  = ~smp_i[ch][SMP_W-1] & sum[SMP_W-1];
    assign sat  = ovf ? {1'b0, {(SMP_W-1){1'b1}}} : sum[SMP_W-1:0];
    assign word_o[ch] = sat & ~mask;

    a_r7_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !smp_i[ch][SMP_W-1] |-> !word_o[ch][SMP_W-1]);
  end

  a_r6_lfsr_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0);
endmodule

// File: rtl/atx_slot_map.sv
module atx_slot_map
  import audio_tx_pkg::*;
#(
  parameter int POS_W = 9
) (
  input  fmt_e                  fmt_i,
  input  logic                  packed_i,
  input  logic                  aux_en_i,
  input  logic [3:0]            drop_i,
  input  logic [1:0][SMP_W-1:0] word_i,
  input  logic [1:0][AUX_W-1:0] aux_i,
  input  logic [POS_W-1:0]      pos_i,
  output logic                  bit_o
);
  localparam int WI_W = $clog2(SMP_W);
  localparam int AI_W = $clog2(AUX_W);

  int              pi;
  int              qi;
  int              wl;
  logic            slot;
  logic [WI_W-1:0] widx;
  logic [AI_W-1:0] aidx;

  always_comb begin
    pi    = int'(pos_i);
    qi    = pi % SUB_W;
    wl    = SMP_W - int'(drop_i);
    slot  = 1'b0;
    widx  = '0;
    aidx  = '0;
    bit_o = 1'b0;
    if (packed_i) begin
      if (pi < 2*PK_W) begin
        slot  = (pi >= PK_W);
        widx  = WI_W'(SMP_W - 1 - (pi % PK_W));
        bit_o = word_i[slot][widx];
      end
    end else if (pi < 2*SUB_W) begin
      slot = (pi >= SUB_W);
      if (fmt_i == FMT_RJ) begin
        if (aux_en_i && qi < AUX_W) begin
          aidx  = AI_W'(AUX_W - 1 - qi);
          bit_o = aux_i[slot][aidx];
        end else if (qi >= SUB_W - wl) begin
          widx  = WI_W'(SMP_W - 1 - (qi - (SUB_W - wl)));
          bit_o = word_i[slot][widx];
        end
      end else begin
        if (qi < wl) begin
          widx  = WI_W'(SMP_W - 1 - qi);
          bit_o = word_i[slot][widx];
        end else if (aux_en_i && qi >= SMP_W) begin
          aidx  = AI_W'(AUX_W - 1 - (qi - SMP_W));
          bit_o = aux_i[slot][aidx];
        end
      end
    end
  end
endmodule

// File: rtl/audio_serial_tx.sv
module audio_serial_tx
  import audio_tx_pkg::*;
#(
  parameter int                POS_W     = 9,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bclk_i,
  input  logic              frame_i,
  input  logic [1:0]        fmt_i,
  input  logic [1:0]        width_i,
  input  logic              packed_i,
  input  logic              aux_en_i,
  input  logic [SMP_W-1:0]  left_i,
  input  logic [SMP_W-1:0]  right_i,
  input  logic [AUX_W-1:0]  aux_left_i,
  input  logic [AUX_W-1:0]  aux_right_i,
  output logic              sdata_o
);
  logic             fall, start;
  logic [POS_W-1:0] pos_q, pos_next;

  fmt_e       fmt_in, fmt_q, fmt_cur;
  logic       pk_in, pk_q, pk_cur;
  logic       aen_q, aen_cur;
  logic [3:0] drop_in, drop_q, drop_cur;

  logic [1:0][SMP_W-1:0] smp_in, dith_word, word_q, word_cur;
  logic [1:0][AUX_W-1:0] aux_in, aux_q, aux_cur;

  logic lj_bit, lj_prev;

  atx_edge_ctrl #(.POS_W(POS_W)) i_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bclk_i     (bclk_i),
    .frame_i    (frame_i),
    .fall_o     (fall),
    .start_o    (start),
    .pos_o      (pos_q),
    .pos_next_o (pos_next)
  );

  assign fmt_in  = fmt_e'(fmt_i);
  assign pk_in   = packed_i & ((fmt_in == FMT_LJ) | (fmt_in == FMT_I2S));
  assign drop_in = drop_count(width_i, pk_in);
  assign smp_in  = {right_i, left_i};
  assign aux_in  = {aux_right_i, aux_left_i};

  atx_dither #(.SEED(LFSR_SEED)) i_dither (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (start),
    .drop_i (drop_in),
    .smp_i  (smp_in),
    .word_o (dith_word)
  );

  // the frame start bit already uses the new capture
  assign fmt_cur  = start ? fmt_in    : fmt_q;
  assign pk_cur   = start ? pk_in     : pk_q;
  assign aen_cur  = start ? aux_en_i  : aen_q;
  assign drop_cur = start ? drop_in   : drop_q;
  assign word_cur = start ? dith_word : word_q;
  assign aux_cur  = start ? aux_in    : aux_q;

  atx_slot_map #(.POS_W(POS_W)) i_map (
    .fmt_i    (fmt_cur),
    .packed_i (pk_cur),
    .aux_en_i (aen_cur),
    .drop_i   (drop_cur),
    .word_i   (word_cur),
    .aux_i    (aux_cur),
    .pos_i    (pos_next),
    .bit_o    (lj_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fmt_q   <= FMT_LJ;
      pk_q    <= 1'b0;
      aen_q   <= 1'b0;
      drop_q  <= '0;
      word_q  <= '0;
      aux_q   <= '0;
      lj_prev <= 1'b0;
      sdata_o <= 1'b0;
    end else begin
      if (start) begin
        fmt_q  <= fmt_in;
        pk_q   <= pk_in;
        aen_q  <= aux_en_i;
        drop_q <= drop_in;
        word_q <= dith_word;
        aux_q  <= aux_in;
      end
      if (fall) begin
        lj_prev <= lj_bit;
        sdata_o <= (fmt_cur == FMT_I2S) ? lj_prev : lj_bit;
      end
    end
  end

  a_r11_change_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall |=> $stable(sdata_o));

  a_r3_quiet_tail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((int'(pos_q) >= (pk_q ? 2*PK_W : 2*SUB_W)) && (fmt_q != FMT_I2S)) |-> !sdata_o);

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fall && start) |=> ($stable(word_q) && $stable(aux_q) && $stable(fmt_q)));
endmodule

// File: tb/test_audio_serial_tx.sv
module test_audio_serial_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b1;
  logic        frame = 1'b0;
  logic [1:0]  fmt = 2'b00;
  logic [1:0]  width = 2'b00;
  logic        pk = 1'b0;
  logic        aen = 1'b0;
  logic [23:0] left = '0, right = '0;
  logic [7:0]  auxl = '0, auxr = '0;
  logic        sdata;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  bit    exp_q[$];
  string tag_q[$];
  int    pos_q[$];

  logic [15:0] m_lfsr = 16'hACE1;
  logic        m_prev = 1'b0;

  always #2 clk = ~clk;

  audio_serial_tx i_audio_serial_tx (
    .clk_i(clk), .rst_ni(rst_n), .bclk_i(bclk), .frame_i(frame),
    .fmt_i(fmt), .width_i(width), .packed_i(pk), .aux_en_i(aen),
    .left_i(left), .right_i(right), .aux_left_i(auxl), .aux_right_i(auxr),
    .sdata_o(sdata)
  );

  function automatic logic [15:0] lfsr_step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic int drop_of(input logic [1:0] wc, input bit epk);
    if (epk) return 8;
    case (wc)
      2'b00: return 0;
      2'b01: return 4;
      2'b10: return 6;
      default: return 8;
    endcase
  endfunction

  // R6 R7: masked dither add, saturate, clear discarded bits
  function automatic logic [23:0] proc(input logic [23:0] s, input logic [7:0] d8, input int drop);
    logic [24:0] sum;
    logic [23:0] mask;
    if (drop == 0) return s;
    mask = (24'd1 << drop) - 24'd1;
    sum = {s[23], s} + {17'd0, d8 & mask[7:0]};
    if (!s[23] && sum[23]) sum[23:0] = 24'h7FFFFF;
    return sum[23:0] & ~mask;
  endfunction

  // R1 R3 R4 R5 R8 R9: left-justified-style bit at a frame position
  function automatic bit model_bit(input logic [1:0] f, input bit epk, input bit ae, input int drop,
                                   input logic [23:0] wl, input logic [23:0] wr,
                                   input logic [7:0] al, input logic [7:0] ar, input int p);
    int q, w;
    logic [23:0] wd;
    logic [7:0]  ad;
    if (epk) begin
      if (p >= 32) return 0;
      wd = (p < 16) ? wl : wr;
      return wd[23 - (p % 16)];
    end
    if (p >= 64) return 0;
    wd = (p < 32) ? wl : wr;
    ad = (p < 32) ? al : ar;
    q = p % 32;
    w = 24 - drop;
    if (f == 2'b11) begin
      if (ae && q < 8) return ad[7 - q];
      if (q >= 32 - w) return wd[23 - (q - (32 - w))];
      return 0;
    end
    if (q < w) return wd[23 - q];
    if (ae && q >= 24) return ad[7 - (q - 24)];
    return 0;
  endfunction

  task automatic drive_bit(input logic lvl);
    @(negedge clk);
    bclk = 1'b0;
    frame = lvl;
    repeat (2) @(negedge clk);
    bclk = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle_bits(input int n);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(1'b0); tag_q.push_back("R11 idle"); pos_q.push_back(k);
      m_prev = 1'b0;
      drive_bit(1'b0);
    end
  endtask

  task automatic run_frame(input logic [1:0] f, input logic [1:0] wc, input bit p, input bit ae,
                           input logic [23:0] l, input logic [23:0] r,
                           input logic [7:0] al, input logic [7:0] ar,
                           input int nbits, input int hi, input bit scramble, input string tag);
    bit epk;
    int drop;
    logic [23:0] wl, wr;
    bit lj, e;
    fmt = f; width = wc; pk = p; aen = ae; left = l; right = r; auxl = al; auxr = ar;
    epk  = p && (f == 2'b00 || f == 2'b01);
    drop = drop_of(wc, epk);
    wl = proc(l, m_lfsr[7:0], drop);
    wr = proc(r, m_lfsr[15:8], drop);
    m_lfsr = lfsr_step(m_lfsr);
    for (int k = 0; k < nbits; k++) begin
      lj = model_bit(f, epk, ae, drop, wl, wr, al, ar, k);
      e  = (f == 2'b01) ? m_prev : lj;
      m_prev = lj;
      exp_q.push_back(e); tag_q.push_back(tag); pos_q.push_back(k);
      drive_bit(k < hi);
      if (scramble && k == 5) begin
        left = ~l; right = ~r; auxl = ~al; auxr = ~ar;
        fmt = 2'b11; width = 2'b11; aen = ~ae; pk = 1'b1;
      end
    end
  endtask

  // monitor: receiver side, samples on the rising bit-clock edge
  always @(posedge bclk) begin
    if (exp_q.size() > 0) begin
      bit e;
      string t;
      int p;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      p = pos_q.pop_front();
      checks++;
      if (sdata !== e) begin
        failures++;
        $display("FAIL %s pos %0d: sdata=%0b expected=%0b", t, p, sdata, e);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      failures++;
      $display("FAIL watchdog: cycles=%0d expected=completion", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    checks++;
    if (sdata !== 1'b0) begin
      failures++;
      $display("FAIL R11 reset: sdata=%0b expected=0", sdata);
    end
    idle_bits(4);
    //          fmt    wc     pk ae  left         right        auxl   auxr   n    hi  scr tag
    run_frame(2'b00, 2'b00, 0, 0, 24'h123456, 24'hABCDEF, 8'h00, 8'h00, 64, 32, 0, "R1 R5 lj24");
    run_frame(2'b00, 2'b00, 0, 1, 24'h0F0F0F, 24'hF0F0F0, 8'hA5, 8'h3C, 64, 32, 0, "R8 lj24 aux");
    run_frame(2'b00, 2'b01, 0, 0, 24'h345678, 24'h876543, 8'h00, 8'h00, 64, 32, 0, "R5 R6 lj20");
    run_frame(2'b00, 2'b11, 0, 0, 24'h7FFFFF, 24'h7FFFC0, 8'h00, 8'h00, 64, 32, 0, "R7 R6 lj16 sat");
    run_frame(2'b01, 2'b00, 0, 1, 24'h89ABCD, 24'h13579B, 8'h81, 8'h7E, 64, 32, 0, "R2 R8 i2s24");
    run_frame(2'b01, 2'b10, 0, 0, 24'h2468AC, 24'hFEDCBA, 8'h00, 8'h00, 64, 32, 0, "R2 R6 i2s18");
    run_frame(2'b10, 2'b00, 0, 1, 24'hC3C3C3, 24'h5A5A5A, 8'hF1, 8'h1F, 128, 1, 0, "R3 R8 tdm24");
    run_frame(2'b10, 2'b11, 0, 0, 24'h7FFFFE, 24'h800001, 8'h00, 8'h00, 128, 1, 0, "R3 R5 tdm16");
    run_frame(2'b11, 2'b00, 0, 1, 24'h654321, 24'hBADCAF, 8'hC9, 8'h36, 64, 32, 0, "R4 R8 rj24");
    run_frame(2'b11, 2'b11, 0, 1, 24'h0055AA, 24'hFFAA55, 8'h96, 8'h69, 64, 32, 0, "R4 R5 rj16");
    run_frame(2'b11, 2'b10, 0, 0, 24'h3CCCCC, 24'hC33333, 8'h00, 8'h00, 64, 32, 0, "R4 R5 rj18");
    run_frame(2'b00, 2'b00, 1, 1, 24'h1234FF, 24'hFEDC00, 8'hFF, 8'hFF, 32, 16, 0, "R9 lj packed");
    run_frame(2'b01, 2'b01, 1, 0, 24'hA0A0A0, 24'h0A0A0A, 8'h00, 8'h00, 32, 16, 0, "R9 R2 i2s packed");
    run_frame(2'b11, 2'b00, 1, 0, 24'h111111, 24'h999999, 8'h00, 8'h00, 64, 32, 0, "R9 rj packed ignored");
    run_frame(2'b00, 2'b00, 0, 1, 24'h5EED00, 24'hC0FFEE, 8'h42, 8'h24, 64, 32, 1, "R10 capture");
    run_frame(2'b00, 2'b01, 0, 0, 24'h7FFFF8, 24'h000007, 8'h00, 8'h00, 64, 32, 0, "R6 R7 lj20 after");
    run_frame(2'b01, 2'b11, 0, 1, 24'h800000, 24'h7FFFFF, 8'hE7, 8'h18, 64, 32, 0, "R2 R7 i2s16");
    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R11 drain: pending=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule